// File: doc/BRIEF.md
# Multi-Kind Match Table

The block is a lookup table of up to 128 entries for a packet forwarding pipeline. Each entry compares four key fields taken from a packet header, and each field uses its own kind of comparison. The identification field is matched under a per-entry care mask, which gives a ternary match; an all-ones mask gives an exact match. The source and destination addresses are matched as prefixes. The total-length field is matched against an inclusive window. When several entries match, the one with the largest combined prefix length wins. The result carries hit or miss, the winning index, the action kind and that entry's action parameters.

Entries are loaded one at a time through a write port that carries the whole entry in a single cycle. A lookup is a single-cycle key-valid strobe, and its result is presented one cycle later. A new key may be offered every cycle. A miss is reported explicitly so that the surrounding control flow can pass the packet on to a fallback table.

Top module: `mkt_match_table`

## Requirements
- R1: A write (`cfg_we`=1) stores the whole entry at `cfg_idx` on the clock edge. A key presented in any later cycle sees the new entry, and a key presented in the same cycle as the write sees the old contents. The indices run from 0 to N_ENTRIES-1, and the top index is usable.
- R2: Reset clears every entry's valid bit. An entry whose valid bit is 0 never matches, whatever its fields or its prefix lengths.
- R3: The identification field matches when `((key_id ^ id) & id_mask) == 0`. A mask of all ones gives an exact match, and a mask of zero accepts any value.
- R4: The source and destination addresses each match when their top `len` bits, counted from the most significant bit, equal the stored value. A length of 0 accepts any address, and a length of 32 or more compares all 32 bits.
- R5: The total-length field matches when `len_lo <= key_len <= len_hi`, inclusive at both bounds. An entry with `len_lo > len_hi` never matches.
- R6: Among the matching valid entries, the winner has the largest sum of source and destination prefix lengths, each clamped to 32. On equal sums the lowest index wins.
- R7: `res_valid` is 1 exactly in the cycle after a cycle with `key_valid`=1. Keys offered in back-to-back cycles give results in back-to-back cycles.
- R8: On a miss, `res_miss`=1, `res_hit`=0, `res_idx`=0, `res_route`=0 and all action parameters are 0. Outside a result cycle, both `res_hit` and `res_miss` are 0.
- R9: The action kind is encoded as route=1 and no-op=0. A route winner outputs its stored destination MAC, source MAC and VLAN ID. A no-op winner outputs hit with `res_route`=0 and all three parameters at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 7 | Entry index to write |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_id | input | 16 | Identification value |
| cfg_id_mask | input | 16 | Identification care mask |
| cfg_src | input | 32 | Source prefix value |
| cfg_src_len | input | 6 | Source prefix length |
| cfg_len_lo | input | 16 | Total-length lower bound |
| cfg_len_hi | input | 16 | Total-length upper bound |
| cfg_dst | input | 32 | Destination prefix value |
| cfg_dst_len | input | 6 | Destination prefix length |
| cfg_route | input | 1 | Action kind: 1 route, 0 no-op |
| cfg_dmac | input | 48 | Route parameter: destination MAC |
| cfg_smac | input | 48 | Route parameter: source MAC |
| cfg_vid | input | 12 | Route parameter: VLAN ID |
| key_valid | input | 1 | Key strobe |
| key_id | input | 16 | Key identification |
| key_src | input | 32 | Key source address |
| key_len | input | 16 | Key total length |
| key_dst | input | 32 | Key destination address |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | A valid entry matched |
| res_miss | output | 1 | No entry matched |
| res_idx | output | 7 | Winning entry index |
| res_route | output | 1 | Winner action is route |
| res_dmac | output | 48 | Destination MAC of the winner |
| res_smac | output | 48 | Source MAC of the winner |
| res_vid | output | 12 | VLAN ID of the winner |

## Verification
Each field kind is tried on its own against otherwise wildcard entries. Keys sit on, just inside and just outside each boundary: a masked identification bit against an unmasked one, the last prefix bit, both range bounds and one beyond each, and an inverted window. The winner rule is tried with overlapping entries whose prefix sums are distinct, equal, and higher only on an invalid entry, which separates largest-sum selection, lowest-index tie breaking and valid gating. A write in the same cycle as a key, and a stream of back-to-back keys ending in a miss, separate the point at which a write takes effect from the result timing.

// File: rtl/mkt_pkg.sv
package mkt_pkg;

  typedef enum logic {ACT_NOOP = 1'b0, ACT_ROUTE = 1'b1} mkt_act_e;

  // Mask with the top plen bits of a w-bit field set.
  function automatic logic [63:0] top_mask(input int unsigned plen, input int unsigned w);
    logic [63:0] m;
    m = '0;
    for (int b = 0; b < 64; b++)
      if (b < w && (b + plen) >= w) m[b] = 1'b1;
    return m;
  endfunction

  function automatic int unsigned clamp_len(input int unsigned plen, input int unsigned w);
    return (plen > w) ? w : plen;
  endfunction

  function automatic logic prefix_hit(input logic [63:0] k, input logic [63:0] v,
                                      input int unsigned plen, input int unsigned w);
    return ((k ^ v) & top_mask(plen, w)) == 64'd0;
  endfunction

  function automatic logic window_hit(input logic [63:0] k, input logic [63:0] lo,
                                      input logic [63:0] hi);
    return (lo <= k) && (k <= hi);
  endfunction

  function automatic logic masked_hit(input logic [63:0] k, input logic [63:0] v,
                                      input logic [63:0] m);
    return ((k ^ v) & m) == 64'd0;
  endfunction

endpackage

// File: rtl/mkt_entry_store.sv
module mkt_entry_store #(
  parameter int N      = 128,
  parameter int ID_W   = 16,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int MAC_W  = 48,
  parameter int VID_W  = 12,
  localparam int IDX_W  = $clog2(N),
  localparam int PLEN_W = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [ID_W-1:0]   cfg_id_mask,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [PLEN_W-1:0] cfg_src_len,
  input  logic [LEN_W-1:0]  cfg_len_lo,
  input  logic [LEN_W-1:0]  cfg_len_hi,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [PLEN_W-1:0] cfg_dst_len,
  input  logic              cfg_route,
  input  logic [MAC_W-1:0]  cfg_dmac,
  input  logic [MAC_W-1:0]  cfg_smac,
  input  logic [VID_W-1:0]  cfg_vid,
  output logic [N-1:0]      e_valid,
  output logic [ID_W-1:0]   e_id      [N],
  output logic [ID_W-1:0]   e_id_mask [N],
  output logic [ADDR_W-1:0] e_src     [N],
  output logic [PLEN_W-1:0] e_src_len [N],
  output logic [LEN_W-1:0]  e_len_lo  [N],
  output logic [LEN_W-1:0]  e_len_hi  [N],
  output logic [ADDR_W-1:0] e_dst     [N],
  output logic [PLEN_W-1:0] e_dst_len [N],
  output logic [N-1:0]      e_route,
  output logic [MAC_W-1:0]  e_dmac    [N],
  output logic [MAC_W-1:0]  e_smac    [N],
  output logic [VID_W-1:0]  e_vid     [N]
);

  // Valid bits are reset; the entry payload is not.
  always_ff @(posedge clk) begin
    if (!rst_n) e_valid <= '0;
    else if (cfg_we) e_valid[cfg_idx] <= cfg_valid;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      e_id[cfg_idx]      <= cfg_id;
      e_id_mask[cfg_idx] <= cfg_id_mask;
      e_src[cfg_idx]     <= cfg_src;
      e_src_len[cfg_idx] <= cfg_src_len;
      e_len_lo[cfg_idx]  <= cfg_len_lo;
      e_len_hi[cfg_idx]  <= cfg_len_hi;
      e_dst[cfg_idx]     <= cfg_dst;
      e_dst_len[cfg_idx] <= cfg_dst_len;
      e_route[cfg_idx]   <= cfg_route;
      e_dmac[cfg_idx]    <= cfg_dmac;
      e_smac[cfg_idx]    <= cfg_smac;
      e_vid[cfg_idx]     <= cfg_vid;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (e_valid[$past(cfg_idx)] == $past(cfg_valid))); // R1

endmodule

// File: rtl/mkt_entry_cmp.sv
module mkt_entry_cmp
  import mkt_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int PLEN_W = $clog2(ADDR_W + 1),
  localparam int SC_W   = $clog2(2 * ADDR_W + 1)
) (
  input  logic              e_valid,
  input  logic [ID_W-1:0]   e_id,
  input  logic [ID_W-1:0]   e_id_mask,
  input  logic [ADDR_W-1:0] e_src,
  input  logic [PLEN_W-1:0] e_src_len,
  input  logic [LEN_W-1:0]  e_len_lo,
  input  logic [LEN_W-1:0]  e_len_hi,
  input  logic [ADDR_W-1:0] e_dst,
  input  logic [PLEN_W-1:0] e_dst_len,
  input  logic [ID_W-1:0]   key_id,
  input  logic [ADDR_W-1:0] key_src,
  input  logic [LEN_W-1:0]  key_len,
  input  logic [ADDR_W-1:0] key_dst,
  output logic              hit,
  output logic [SC_W-1:0]   score
);

  // Per-field match events, named for observation.
  logic id_ok, src_ok, len_ok, dst_ok;

  always_comb begin
    id_ok  = masked_hit(64'(key_id), 64'(e_id), 64'(e_id_mask));                 // R3
    src_ok = prefix_hit(64'(key_src), 64'(e_src), 32'(e_src_len), ADDR_W);        // R4
    dst_ok = prefix_hit(64'(key_dst), 64'(e_dst), 32'(e_dst_len), ADDR_W);        // R4
    len_ok = window_hit(64'(key_len), 64'(e_len_lo), 64'(e_len_hi));              // R5
    hit    = e_valid && id_ok && src_ok && dst_ok && len_ok;                      // R2
    score  = SC_W'(clamp_len(32'(e_src_len), ADDR_W) + clamp_len(32'(e_dst_len), ADDR_W));
  end

endmodule

// File: rtl/mkt_arbiter.sv
module mkt_arbiter #(
  parameter int N    = 128,
  parameter int SC_W = 7,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hit_vec,
  input  logic [SC_W-1:0]  score [N],
  output logic             found,
  output logic [IDX_W-1:0] win_idx
);

  logic [SC_W-1:0] best;

  // Ascending scan with strict comparison keeps the lowest index on ties.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i] && (!found || score[i] > best)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        best    = score[i];
      end
    end
  end

  always_comb begin
    AST_FOUND_MEANS_HIT: assert (found == (|hit_vec)); // R8
    if (found) begin
      AST_WIN_IS_HIT: assert (hit_vec[win_idx]); // R6
    end
    for (int j = 0; j < N; j++) begin
      if (found && hit_vec[j]) begin
        AST_WIN_BEST: assert (score[j] <= score[win_idx]); // R6
        if (j < int'(win_idx)) begin
          AST_TIE_LOWEST: assert (score[j] < score[win_idx]); // R6
        end
      end
    end
  end

endmodule

// File: rtl/mkt_match_table.sv
module mkt_match_table
  import mkt_pkg::*;
#(
  parameter int N_ENTRIES = 128,
  parameter int ID_W      = 16,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAC_W     = 48,
  parameter int VID_W     = 12,
  localparam int IDX_W  = $clog2(N_ENTRIES),
  localparam int PLEN_W = $clog2(ADDR_W + 1),
  localparam int SC_W   = $clog2(2 * ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [ID_W-1:0]   cfg_id_mask,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [PLEN_W-1:0] cfg_src_len,
  input  logic [LEN_W-1:0]  cfg_len_lo,
  input  logic [LEN_W-1:0]  cfg_len_hi,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [PLEN_W-1:0] cfg_dst_len,
  input  logic              cfg_route,
  input  logic [MAC_W-1:0]  cfg_dmac,
  input  logic [MAC_W-1:0]  cfg_smac,
  input  logic [VID_W-1:0]  cfg_vid,
  input  logic              key_valid,
  input  logic [ID_W-1:0]   key_id,
  input  logic [ADDR_W-1:0] key_src,
  input  logic [LEN_W-1:0]  key_len,
  input  logic [ADDR_W-1:0] key_dst,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic [IDX_W-1:0]  res_idx,
  output logic              res_route,
  output logic [MAC_W-1:0]  res_dmac,
  output logic [MAC_W-1:0]  res_smac,
  output logic [VID_W-1:0]  res_vid
);

  logic [N_ENTRIES-1:0] e_valid, e_route, hit_vec;
  logic [ID_W-1:0]   e_id      [N_ENTRIES];
  logic [ID_W-1:0]   e_id_mask [N_ENTRIES];
  logic [ADDR_W-1:0] e_src     [N_ENTRIES];
  logic [PLEN_W-1:0] e_src_len [N_ENTRIES];
  logic [LEN_W-1:0]  e_len_lo  [N_ENTRIES];
  logic [LEN_W-1:0]  e_len_hi  [N_ENTRIES];
  logic [ADDR_W-1:0] e_dst     [N_ENTRIES];
  logic [PLEN_W-1:0] e_dst_len [N_ENTRIES];
  logic [MAC_W-1:0]  e_dmac    [N_ENTRIES];
  logic [MAC_W-1:0]  e_smac    [N_ENTRIES];
  logic [VID_W-1:0]  e_vid     [N_ENTRIES];
  logic [SC_W-1:0]   score     [N_ENTRIES];
  logic              found;
  logic [IDX_W-1:0]  win_idx;
  logic              win_route;

  mkt_entry_store #(.N(N_ENTRIES), .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                    .MAC_W(MAC_W), .VID_W(VID_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_id(cfg_id), .cfg_id_mask(cfg_id_mask), .cfg_src(cfg_src), .cfg_src_len(cfg_src_len),
    .cfg_len_lo(cfg_len_lo), .cfg_len_hi(cfg_len_hi), .cfg_dst(cfg_dst),
    .cfg_dst_len(cfg_dst_len), .cfg_route(cfg_route), .cfg_dmac(cfg_dmac),
    .cfg_smac(cfg_smac), .cfg_vid(cfg_vid),
    .e_valid(e_valid), .e_id(e_id), .e_id_mask(e_id_mask), .e_src(e_src),
    .e_src_len(e_src_len), .e_len_lo(e_len_lo), .e_len_hi(e_len_hi), .e_dst(e_dst),
    .e_dst_len(e_dst_len), .e_route(e_route), .e_dmac(e_dmac), .e_smac(e_smac),
    .e_vid(e_vid)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    mkt_entry_cmp #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cmp (
      .e_valid(e_valid[g]), .e_id(e_id[g]), .e_id_mask(e_id_mask[g]), .e_src(e_src[g]),
      .e_src_len(e_src_len[g]), .e_len_lo(e_len_lo[g]), .e_len_hi(e_len_hi[g]),
      .e_dst(e_dst[g]), .e_dst_len(e_dst_len[g]),
      .key_id(key_id), .key_src(key_src), .key_len(key_len), .key_dst(key_dst),
      .hit(hit_vec[g]), .score(score[g])
    );
  end

  mkt_arbiter #(.N(N_ENTRIES), .SC_W(SC_W)) u_arb (
    .hit_vec(hit_vec), .score(score), .found(found), .win_idx(win_idx)
  );

  assign win_route = found && (mkt_act_e'(e_route[win_idx]) == ACT_ROUTE);

  // Single result register stage: key sampled on edge k, result visible after edge k.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_route <= 1'b0;
      res_dmac  <= '0;
      res_smac  <= '0;
      res_vid   <= '0;
    end else begin
      res_valid <= key_valid;
      res_hit   <= key_valid && found;
      res_idx   <= (key_valid && found) ? win_idx : '0;
      res_route <= key_valid && win_route;
      res_dmac  <= (key_valid && win_route) ? e_dmac[win_idx] : '0;
      res_smac  <= (key_valid && win_route) ? e_smac[win_idx] : '0;
      res_vid   <= (key_valid && win_route) ? e_vid[win_idx]  : '0;
    end
  end

  assign res_miss = res_valid && !res_hit;

  AST_RES_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> res_valid); // R7
  AST_NO_RES_NO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> !res_valid); // R7
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (!res_route && res_idx == '0 && res_dmac == '0 && res_smac == '0
                  && res_vid == '0)); // R8
  AST_NOOP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit && !res_route) |-> (res_dmac == '0 && res_smac == '0 && res_vid == '0)); // R9
  AST_WIN_WAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (($past(e_valid) & (N_ENTRIES'(1) << res_idx)) != '0)); // R2

endmodule

// File: tb/sim_mkt_match_table.sv
module sim_mkt_match_table;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 0, cfg_valid = 0, cfg_route = 0, key_valid = 0;
  logic [6:0]  cfg_idx = 0;
  logic [15:0] cfg_id = 0, cfg_id_mask = 0, cfg_len_lo = 0, cfg_len_hi = 0;
  logic [31:0] cfg_src = 0, cfg_dst = 0;
  logic [5:0]  cfg_src_len = 0, cfg_dst_len = 0;
  logic [47:0] cfg_dmac = 0, cfg_smac = 0;
  logic [11:0] cfg_vid = 0;
  logic [15:0] key_id = 0, key_len = 0;
  logic [31:0] key_src = 0, key_dst = 0;
  logic        res_valid, res_hit, res_miss, res_route;
  logic [6:0]  res_idx;
  logic [47:0] res_dmac, res_smac;
  logic [11:0] res_vid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  mkt_match_table u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_id(cfg_id), .cfg_id_mask(cfg_id_mask), .cfg_src(cfg_src), .cfg_src_len(cfg_src_len),
    .cfg_len_lo(cfg_len_lo), .cfg_len_hi(cfg_len_hi), .cfg_dst(cfg_dst),
    .cfg_dst_len(cfg_dst_len), .cfg_route(cfg_route), .cfg_dmac(cfg_dmac),
    .cfg_smac(cfg_smac), .cfg_vid(cfg_vid), .key_valid(key_valid), .key_id(key_id),
    .key_src(key_src), .key_len(key_len), .key_dst(key_dst), .res_valid(res_valid),
    .res_hit(res_hit), .res_miss(res_miss), .res_idx(res_idx), .res_route(res_route),
    .res_dmac(res_dmac), .res_smac(res_smac), .res_vid(res_vid)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic put_entry(input int idx, input bit v, input logic [15:0] id, input logic [15:0] idm,
                           input logic [31:0] src, input int sl, input int lo, input int hi,
                           input logic [31:0] dst, input int dl, input bit rt,
                           input logic [47:0] dm, input logic [47:0] sm, input logic [11:0] vid);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 7'(idx); cfg_valid = v; cfg_id = id; cfg_id_mask = idm;
    cfg_src = src; cfg_src_len = 6'(sl); cfg_len_lo = 16'(lo); cfg_len_hi = 16'(hi);
    cfg_dst = dst; cfg_dst_len = 6'(dl); cfg_route = rt; cfg_dmac = dm; cfg_smac = sm;
    cfg_vid = vid;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Wildcard entry: any id, any addresses, any length.
  task automatic put_wild(input int idx, input bit rt, input logic [47:0] dm,
                          input logic [47:0] sm, input logic [11:0] vid);
    put_entry(idx, 1, 0, 0, 0, 0, 0, 16'hFFFF, 0, 0, rt, dm, sm, vid);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 128; i++) put_entry(i, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic look(input logic [15:0] id, input logic [31:0] src, input logic [15:0] ln,
                      input logic [31:0] dst);
    @(negedge clk);
    key_valid = 1; key_id = id; key_src = src; key_len = ln; key_dst = dst;
    @(negedge clk);
    key_valid = 0;
  endtask

  task automatic expect_res(input string tag, input bit hit, input int idx, input bit rt,
                            input logic [47:0] dm, input logic [47:0] sm, input logic [11:0] vid);
    chk({tag, " valid"}, 64'(res_valid), 64'd1);
    chk({tag, " hit"}, 64'(res_hit), 64'(hit));
    chk({tag, " miss"}, 64'(res_miss), 64'(!hit));
    chk({tag, " idx"}, 64'(res_idx), 64'(idx));
    chk({tag, " route"}, 64'(res_route), 64'(rt));
    chk({tag, " dmac"}, 64'(res_dmac), 64'(dm));
    chk({tag, " smac"}, 64'(res_smac), 64'(sm));
    chk({tag, " vid"}, 64'(res_vid), 64'(vid));
  endtask

  task automatic expect_miss(input string tag);
    expect_res(tag, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    chk("R7 reset res_valid", 64'(res_valid), 0);
    chk("R8 reset res_hit", 64'(res_hit), 0);
    chk("R8 reset res_miss", 64'(res_miss), 0);
    look(16'h1234, 32'h0A000001, 16'd64, 32'h14000001);
    expect_miss("R2 empty table after reset");
    @(negedge clk);
    chk("R7 idle no result", 64'(res_valid), 0);
  endtask

  task automatic t_ternary();
    clear_all();
    put_entry(0, 1, 16'h1234, 16'hFFFF, 0, 0, 0, 16'hFFFF, 0, 0, 1, 48'hA1, 48'hB2, 12'hC3);
    look(16'h1234, 32'h5, 16'd9, 32'h7);
    expect_res("R3 exact id equal", 1, 0, 1, 48'hA1, 48'hB2, 12'hC3);
    look(16'h1235, 32'h5, 16'd9, 32'h7);
    expect_miss("R3 exact id off by one");
    put_entry(0, 1, 16'h1234, 16'hFF00, 0, 0, 0, 16'hFFFF, 0, 0, 1, 48'hA1, 48'hB2, 12'hC3);
    look(16'h12AB, 0, 0, 0);
    expect_res("R3 masked low byte ignored", 1, 0, 1, 48'hA1, 48'hB2, 12'hC3);
    look(16'h13AB, 0, 0, 0);
    expect_miss("R3 cared bit differs");
  endtask

  task automatic t_prefix();
    clear_all();
    put_entry(1, 1, 0, 0, 32'h0A000000, 8, 0, 16'hFFFF, 0, 0, 1, 48'h11, 48'h22, 12'h33);
    look(0, 32'h0A010203, 0, 32'hFFFFFFFF);
    expect_res("R4 src /8 inside", 1, 1, 1, 48'h11, 48'h22, 12'h33);
    look(0, 32'h0B000000, 0, 0);
    expect_miss("R4 src /8 outside");
    put_entry(1, 1, 0, 0, 0, 0, 0, 16'hFFFF, 32'hC0A80101, 32, 1, 48'h11, 48'h22, 12'h33);
    look(0, 32'h12345678, 0, 32'hC0A80101);
    expect_res("R4 dst /32 exact", 1, 1, 1, 48'h11, 48'h22, 12'h33);
    look(0, 0, 0, 32'hC0A80100);
    expect_miss("R4 dst /32 last bit differs");
  endtask

  task automatic t_window();
    clear_all();
    put_entry(4, 1, 0, 0, 0, 0, 100, 200, 0, 0, 1, 48'h44, 48'h45, 12'h46);
    look(0, 0, 16'd100, 0);
    expect_res("R5 lower bound", 1, 4, 1, 48'h44, 48'h45, 12'h46);
    look(0, 0, 16'd200, 0);
    expect_res("R5 upper bound", 1, 4, 1, 48'h44, 48'h45, 12'h46);
    look(0, 0, 16'd99, 0);
    expect_miss("R5 below");
    look(0, 0, 16'd201, 0);
    expect_miss("R5 above");
    put_entry(4, 1, 0, 0, 0, 0, 300, 250, 0, 0, 1, 48'h44, 48'h45, 12'h46);
    look(0, 0, 16'd275, 0);
    expect_miss("R5 inverted window");
  endtask

  task automatic t_priority();
    clear_all();
    put_entry(2, 0, 0, 0, 32'h0A0B0C00, 24, 0, 16'hFFFF, 0, 0, 1, 48'h2, 48'h2, 12'h2);
    put_entry(3, 1, 0, 0, 32'h0A000000, 8, 0, 16'hFFFF, 0, 0, 1, 48'h3, 48'h3, 12'h3);
    put_entry(5, 1, 0, 0, 32'h0A0B0000, 16, 0, 16'hFFFF, 0, 0, 1, 48'h5, 48'h5, 12'h5);
    put_entry(7, 1, 0, 0, 32'h0A000000, 8, 0, 16'hFFFF, 32'h14000000, 8, 1, 48'h7, 48'h7, 12'h7);
    look(0, 32'h0A0B0C0D, 0, 32'h14000001);
    expect_res("R6 tie 16 lowest idx, R2 invalid /24 skipped", 1, 5, 1, 48'h5, 48'h5, 12'h5);
    look(0, 32'h0A0C0000, 0, 32'h15000000);
    expect_res("R6 single match", 1, 3, 1, 48'h3, 48'h3, 12'h3);
    look(0, 32'h0A0C0000, 0, 32'h14000000);
    expect_res("R6 larger sum wins over lower idx", 1, 7, 1, 48'h7, 48'h7, 12'h7);
  endtask

  task automatic t_noop();
    clear_all();
    put_wild(9, 0, 48'hDEADBEEF0001, 48'hCAFE00000002, 12'hABC);
    look(16'h55, 32'h1, 16'd3, 32'h2);
    expect_res("R9 no-op outputs zero params", 1, 9, 0, 0, 0, 0);
  endtask

  task automatic t_write_timing();
    clear_all();
    @(negedge clk);
    cfg_we = 1; cfg_idx = 7'd127; cfg_valid = 1; cfg_id = 0; cfg_id_mask = 0;
    cfg_src = 0; cfg_src_len = 0; cfg_len_lo = 0; cfg_len_hi = 16'hFFFF; cfg_dst = 0;
    cfg_dst_len = 0; cfg_route = 1; cfg_dmac = 48'h7F; cfg_smac = 48'h7E; cfg_vid = 12'h7D;
    key_valid = 1; key_id = 0; key_src = 0; key_len = 0; key_dst = 0;
    @(negedge clk);
    cfg_we = 0; key_valid = 0;
    expect_miss("R1 same-cycle key sees old table");
    look(0, 0, 0, 0);
    expect_res("R1 later key sees top index", 1, 127, 1, 48'h7F, 48'h7E, 12'h7D);
  endtask

  task automatic t_stream();
    clear_all();
    put_entry(10, 1, 16'd1, 16'hFFFF, 0, 0, 0, 16'hFFFF, 0, 0, 1, 48'hA, 48'hA, 12'hA);
    put_entry(11, 1, 16'd2, 16'hFFFF, 0, 0, 0, 16'hFFFF, 0, 0, 1, 48'hB, 48'hB, 12'hB);
    @(negedge clk);
    key_valid = 1; key_id = 16'd1; key_src = 0; key_len = 0; key_dst = 0;
    @(negedge clk);
    expect_res("R7 stream first", 1, 10, 1, 48'hA, 48'hA, 12'hA);
    key_id = 16'd2;
    @(negedge clk);
    expect_res("R7 stream second", 1, 11, 1, 48'hB, 48'hB, 12'hB);
    key_id = 16'd3;
    @(negedge clk);
    expect_miss("R7 R8 stream third misses");
    key_valid = 0;
    @(negedge clk);
    chk("R7 no result after strobe drops", 64'(res_valid), 0);
    chk("R8 no miss outside result", 64'(res_miss), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ternary();
    t_prefix();
    t_window();
    t_priority();
    t_noop();
    t_write_timing();
    t_stream();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule